// File: doc/BRIEF.md
# Strobe-Framed PCM and ADPCM Serial Port

This block is the serial edge of one transcoder channel pair. Two enable strobes, A and B, each open a window of eight bit clocks. Through those windows the block shifts a 16-bit linear PCM sample out and another one in, and it moves one ADPCM field each way. A rate select sets the field: four bits, three bits, or four packed 2-bit codes that fill all eight bits. The transcoding core supplies the words to send. It collects the words received and watches a one-cycle valid pulse for each lane.

The whole block runs on the bit clock. Serial inputs are sampled on the falling edge. Window state and serial outputs change on the rising edge. A rising strobe seen at a rising edge starts a window at bit 0. A PCM word covers two windows: its high octet goes in window A and its low octet in window B. At the 4-bit and 3-bit rates the ADPCM field sits in window A. At the packed 2-bit rate a slot select puts the field in window A or in window B.

The sequencer has three states. `ST_IDLE` moves to `ST_WIN_A` on a rising strobe A and to `ST_WIN_B` on a rising strobe B. A rising strobe A wins when both rise together. Either window state moves back to `ST_IDLE` after its eighth bit. A new rising strobe in any state restarts the matching window at bit 0.

Top module: `framed_serial_port`

## Requirements
- R1: `pcm_sdo` sends the PCM transmit word most significant bit first. Bits 15 down to 8 go out in window A and bits 7 down to 0 in window B, one bit per rising bit-clock edge starting at the edge that opens the window.
- R2: `pcm_sdi` is sampled on falling edges. The eight bits from window A become bits 15..8 of `pcm_rx_word`, first bit highest. The eight bits from window B become bits 7..0.
- R3: `pcm_rx_valid` is high for exactly one cycle, at the rising edge after the last bit of window B is sampled. It stays low during and after window A.
- R4: With `rate_sel`=00 (4-bit codes) the ADPCM field uses window A. `adp_sdo` sends `adp_tx_code[7:4]`, bit 7 (I1) first. The first four received bits land in `adp_rx_code[7:4]`, and `adp_rx_code[3:0]` reads 0.
- R5: With `rate_sel`=01 (3-bit codes) the field uses window A. `adp_sdo` sends `adp_tx_code[7:5]` and then a 0 in the I4 position. The received I4 bit is ignored: `adp_rx_code[4:0]` reads 0 whatever the line carried there.
- R6: With `rate_sel`=10 or 11 (packed 2-bit codes) all eight bits of `adp_tx_code` and `adp_rx_code` are used, bit 7 first. The field uses window A when `slot_sel`=0 and window B when `slot_sel`=1.
- R7: `adp_rx_valid` is high for exactly one cycle, at the rising edge after the last field bit is sampled. It pulses once per frame and only in the selected window.
- R8: Both serial outputs are 0 outside their active window. `adp_sdo` is also 0 in window positions beyond the field. ADPCM input in the unselected window leaves `adp_rx_code` unchanged.
- R9: A rising strobe restarts the bit count at 0, even in the middle of a window. The transmit word is captured again at that edge.
- R10: While `rst_n` is low, all outputs are 0.
- R11: The PCM transmit word is captured at the start of window A. Changing `pcm_tx_word` before window B does not change the low octet sent in window B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; inputs are sampled on the falling edge, outputs change on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_a | input | 1 | Enable strobe for window A |
| strobe_b | input | 1 | Enable strobe for window B |
| rate_sel | input | 2 | ADPCM rate: 00 4-bit, 01 3-bit, 1x packed 2-bit |
| slot_sel | input | 1 | Window for the packed 2-bit field: 0 A, 1 B |
| pcm_sdi | input | 1 | Serial linear PCM input |
| adp_sdi | input | 1 | Serial ADPCM input |
| pcm_tx_word | input | 16 | PCM word to transmit |
| adp_tx_code | input | 8 | ADPCM field to transmit, left aligned |
| pcm_sdo | output | 1 | Serial linear PCM output |
| adp_sdo | output | 1 | Serial ADPCM output |
| pcm_rx_word | output | 16 | Last received PCM word |
| pcm_rx_valid | output | 1 | One-cycle pulse when a PCM word is complete |
| adp_rx_code | output | 8 | Last received ADPCM field, left aligned |
| adp_rx_valid | output | 1 | One-cycle pulse when an ADPCM field is complete |

## Verification
The main loop runs each rate with unlike transmit and receive patterns. It drives the inverted ADPCM pattern into the unselected window, so capture in the wrong window shows up as a wrong code. The 3-bit frames drive a 1 in the I4 position, which separates an ignored I4 from a captured one. Both slot choices of the packed rate are run, and the PCM transmit word is changed between windows to show that it is captured at window start. Directed tests cover the reset values, quiet outputs with no strobe, and a strobe that rises again in the middle of a window.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WIN_A = 2'd1,
        ST_WIN_B = 2'd2
    } win_state_e;

    typedef enum logic [1:0] {
        RATE_32K  = 2'b00,
        RATE_24K  = 2'b01,
        RATE_16K  = 2'b10,
        RATE_16KX = 2'b11
    } rate_e;
endpackage

// File: rtl/fsp_window_fsm.sv
// Window sequencer: a rising strobe opens a window of OCT_W bit clocks.
module fsp_window_fsm
    import fsp_pkg::*;
#(
    parameter int OCT_W = 8,
    localparam int CW = $clog2(OCT_W)
) (
    input  logic          bclk,
    input  logic          rst_n,
    input  logic          strobe_a,
    input  logic          strobe_b,
    output win_state_e    st,
    output logic [CW-1:0] bit_cnt,
    output logic          rise_a,
    output logic          rise_b
);
    localparam logic [CW-1:0] LAST = CW'(OCT_W - 1);

    logic          a_q, b_q;
    win_state_e    nxt_st;
    logic [CW-1:0] nxt_cnt;

    assign rise_a = strobe_a & ~a_q;
    assign rise_b = strobe_b & ~b_q;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            a_q     <= 1'b0;
            b_q     <= 1'b0;
        end else begin
            st      <= nxt_st;
            bit_cnt <= nxt_cnt;
            a_q     <= strobe_a;
            b_q     <= strobe_b;
        end
    end

    always_comb begin
        nxt_st  = st;
        nxt_cnt = bit_cnt;
        if (rise_a) begin
            nxt_st  = ST_WIN_A;
            nxt_cnt = '0;
        end else if (rise_b) begin
            nxt_st  = ST_WIN_B;
            nxt_cnt = '0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_WIN_A, ST_WIN_B: begin
                    if (bit_cnt == LAST) begin
                        nxt_st  = ST_IDLE;
                        nxt_cnt = '0;
                    end else begin
                        nxt_cnt = bit_cnt + 1'b1;
                    end
                end
                default: nxt_st = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fsp_pcm_lane.sv
// Linear PCM lane: high octet in window A, low octet in window B.
// OCT_W must be a power of two.
module fsp_pcm_lane
    import fsp_pkg::*;
#(
    parameter int OCT_W = 8,
    localparam int CW = $clog2(OCT_W),
    localparam int PW = 2 * OCT_W
) (
    input  logic          bclk,
    input  logic          rst_n,
    input  win_state_e    st,
    input  logic [CW-1:0] bit_cnt,
    input  logic          rise_a,
    input  logic [PW-1:0] tx_word,
    input  logic          sdi,
    output logic          sdo,
    output logic [PW-1:0] rx_word,
    output logic          rx_valid
);
    localparam logic [CW-1:0] LAST = CW'(OCT_W - 1);

    logic [PW-1:0] tx_hold;
    logic [PW-1:0] rx_sh;
    logic [CW:0]   idx;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold  <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (rise_a) tx_hold <= tx_word;
            rx_valid <= (st == ST_WIN_B) && (bit_cnt == LAST);
        end
    end

    // index PW-1-cnt in window A, OCT_W-1-cnt in window B
    assign idx = {(st == ST_WIN_A), ~bit_cnt};
    assign sdo = (st != ST_IDLE) ? tx_hold[idx] : 1'b0;

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            rx_word <= '0;
        end else if (st != ST_IDLE) begin
            rx_sh <= {rx_sh[PW-2:0], sdi};
            if (st == ST_WIN_B && bit_cnt == LAST)
                rx_word <= {rx_sh[PW-2:0], sdi};
        end
    end
endmodule

// File: rtl/fsp_adpcm_lane.sv
// ADPCM lane: rate-dependent field width and window choice.
module fsp_adpcm_lane
    import fsp_pkg::*;
#(
    parameter int OCT_W = 8,
    localparam int CW = $clog2(OCT_W),
    localparam int CODE_W = OCT_W / 2
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  win_state_e       st,
    input  logic [CW-1:0]    bit_cnt,
    input  logic             rise_a,
    input  logic             rise_b,
    input  logic [1:0]       rate_sel,
    input  logic             slot_sel,
    input  logic [OCT_W-1:0] tx_code,
    input  logic             sdi,
    output logic             sdo,
    output logic [OCT_W-1:0] rx_code,
    output logic             rx_valid
);
    logic [OCT_W-1:0] mask;
    logic [CW-1:0]    last_idx;
    logic [CW-1:0]    lsh;
    win_state_e       my_win;
    logic             in_win, start;
    logic [OCT_W-1:0] tx_hold, rx_sh, full;

    always_comb begin
        unique case (rate_sel)
            RATE_32K: begin
                mask     = {{CODE_W{1'b1}}, {CODE_W{1'b0}}};
                last_idx = CW'(CODE_W - 1);
                lsh      = CW'(CODE_W);
                my_win   = ST_WIN_A;
            end
            RATE_24K: begin
                mask     = {{(CODE_W-1){1'b1}}, {(CODE_W+1){1'b0}}};
                last_idx = CW'(CODE_W - 1);
                lsh      = CW'(CODE_W);
                my_win   = ST_WIN_A;
            end
            default: begin
                mask     = '1;
                last_idx = CW'(OCT_W - 1);
                lsh      = '0;
                my_win   = slot_sel ? ST_WIN_B : ST_WIN_A;
            end
        endcase
    end

    assign in_win = (st == my_win);
    assign start  = (my_win == ST_WIN_A) ? rise_a : rise_b;
    assign sdo    = in_win ? tx_hold[~bit_cnt] : 1'b0;
    assign full   = {rx_sh[OCT_W-2:0], sdi};

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold  <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (start) tx_hold <= tx_code & mask;
            rx_valid <= in_win && (bit_cnt == last_idx);
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            rx_code <= '0;
        end else if (in_win) begin
            rx_sh <= full;
            if (bit_cnt == last_idx)
                rx_code <= (full << lsh) & mask;
        end
    end
endmodule

// File: rtl/framed_serial_port.sv
module framed_serial_port
    import fsp_pkg::*;
#(
    parameter int OCT_W = 8,
    localparam int CW = $clog2(OCT_W),
    localparam int PW = 2 * OCT_W
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             strobe_a,
    input  logic             strobe_b,
    input  logic [1:0]       rate_sel,
    input  logic             slot_sel,
    input  logic             pcm_sdi,
    input  logic             adp_sdi,
    input  logic [PW-1:0]    pcm_tx_word,
    input  logic [OCT_W-1:0] adp_tx_code,
    output logic             pcm_sdo,
    output logic             adp_sdo,
    output logic [PW-1:0]    pcm_rx_word,
    output logic             pcm_rx_valid,
    output logic [OCT_W-1:0] adp_rx_code,
    output logic             adp_rx_valid
);
    win_state_e    st;
    logic [CW-1:0] bit_cnt;
    logic          rise_a, rise_b;

    fsp_window_fsm #(.OCT_W(OCT_W)) u_fsm (
        .bclk(bclk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
        .st(st), .bit_cnt(bit_cnt), .rise_a(rise_a), .rise_b(rise_b)
    );

    fsp_pcm_lane #(.OCT_W(OCT_W)) u_pcm (
        .bclk(bclk), .rst_n(rst_n), .st(st), .bit_cnt(bit_cnt), .rise_a(rise_a),
        .tx_word(pcm_tx_word), .sdi(pcm_sdi), .sdo(pcm_sdo),
        .rx_word(pcm_rx_word), .rx_valid(pcm_rx_valid)
    );

    fsp_adpcm_lane #(.OCT_W(OCT_W)) u_adp (
        .bclk(bclk), .rst_n(rst_n), .st(st), .bit_cnt(bit_cnt),
        .rise_a(rise_a), .rise_b(rise_b), .rate_sel(rate_sel), .slot_sel(slot_sel),
        .tx_code(adp_tx_code), .sdi(adp_sdi), .sdo(adp_sdo),
        .rx_code(adp_rx_code), .rx_valid(adp_rx_valid)
    );
endmodule

module fsp_checker
    import fsp_pkg::*;
#(
    parameter int OCT_W = 8,
    localparam int CW = $clog2(OCT_W)
) (
    input logic          bclk,
    input logic          rst_n,
    input logic          strobe_a,
    input win_state_e    st,
    input logic [CW-1:0] bit_cnt,
    input logic          pcm_sdo,
    input logic          adp_sdo,
    input logic          pcm_rx_valid,
    input logic          adp_rx_valid
);
    a_r3_pcm_valid_pulse: assert property (@(posedge bclk) disable iff (!rst_n)
        pcm_rx_valid |=> !pcm_rx_valid);

    a_r3_pcm_valid_after_b: assert property (@(posedge bclk) disable iff (!rst_n)
        pcm_rx_valid |-> $past(st) == ST_WIN_B);

    a_r7_adp_valid_pulse: assert property (@(posedge bclk) disable iff (!rst_n)
        adp_rx_valid |=> !adp_rx_valid);

    a_r8_quiet_when_idle: assert property (@(posedge bclk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!pcm_sdo && !adp_sdo));

    a_r9_restart_on_rise: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(strobe_a) |=> (st == ST_WIN_A && bit_cnt == '0));
endmodule

bind framed_serial_port fsp_checker #(.OCT_W(OCT_W)) u_chk (
    .bclk(bclk), .rst_n(rst_n), .strobe_a(strobe_a), .st(st), .bit_cnt(bit_cnt),
    .pcm_sdo(pcm_sdo), .adp_sdo(adp_sdo),
    .pcm_rx_valid(pcm_rx_valid), .adp_rx_valid(adp_rx_valid)
);

// File: tb/sim_framed_serial_port.sv
`timescale 1ns/1ps
module sim_framed_serial_port;
    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_a = 1'b0, strobe_b = 1'b0;
    logic [1:0]  rate_sel = 2'b00;
    logic        slot_sel = 1'b0;
    logic        pcm_sdi = 1'b0, adp_sdi = 1'b0;
    logic [15:0] pcm_tx_word = '0;
    logic [7:0]  adp_tx_code = '0;
    logic        pcm_sdo, adp_sdo, pcm_rx_valid, adp_rx_valid;
    logic [15:0] pcm_rx_word;
    logic [7:0]  adp_rx_code;

    int n_chk = 0;
    int n_fail = 0;

    always #4 bclk = ~bclk;

    framed_serial_port u0 (
        .bclk(bclk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
        .rate_sel(rate_sel), .slot_sel(slot_sel), .pcm_sdi(pcm_sdi), .adp_sdi(adp_sdi),
        .pcm_tx_word(pcm_tx_word), .adp_tx_code(adp_tx_code),
        .pcm_sdo(pcm_sdo), .adp_sdo(adp_sdo), .pcm_rx_word(pcm_rx_word),
        .pcm_rx_valid(pcm_rx_valid), .adp_rx_code(adp_rx_code), .adp_rx_valid(adp_rx_valid)
    );

    typedef struct packed {
        logic [1:0]  rate;
        logic        slot;
        logic [15:0] ptx;
        logic [7:0]  atx;
        logic [15:0] pin;
        logic [7:0]  ain;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 16'hA5C3, 8'hB7, 16'h1234, 8'h9F},
        '{2'b01, 1'b0, 16'h8001, 8'hFF, 16'hFEDC, 8'hF0},
        '{2'b10, 1'b0, 16'h7FFE, 8'h6C, 16'h0F0F, 8'hA5},
        '{2'b10, 1'b1, 16'h0000, 8'h93, 16'hFFFF, 8'h5A},
        '{2'b11, 1'b1, 16'hFFFF, 8'h01, 16'h8000, 8'h3C},
        '{2'b01, 1'b0, 16'h3C3C, 8'h1E, 16'h0001, 8'h1F},
        '{2'b00, 1'b0, 16'h5A5A, 8'h0F, 16'hC3C3, 8'h6B}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_mask(input logic [1:0] r);
        if (r == 2'b00) return 8'hF0;
        if (r == 2'b01) return 8'hE0;
        return 8'hFF;
    endfunction

    function automatic string rate_req(input logic [1:0] r);
        if (r == 2'b00) return "R4";
        if (r == 2'b01) return "R5";
        return "R6";
    endfunction

    // one window of eight bits on strobe A (which=0) or B (which=1)
    task automatic run_win(input logic which, input logic [7:0] pin, input logic [7:0] ain,
                           output logic [7:0] pout, output logic [7:0] aout,
                           output int pcnt, output int acnt, output logic quiet);
        @(negedge bclk); #1;
        if (which) strobe_b = 1'b1; else strobe_a = 1'b1;
        pcnt = 0; acnt = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge bclk); #1;
            pcm_sdi = pin[7-k];
            adp_sdi = ain[7-k];
            #1;
            pout[7-k] = pcm_sdo;
            aout[7-k] = adp_sdo;
            pcnt += int'(pcm_rx_valid);
            acnt += int'(adp_rx_valid);
        end
        @(negedge bclk); #1;
        strobe_a = 1'b0; strobe_b = 1'b0;
        @(posedge bclk); #2;
        pcnt += int'(pcm_rx_valid);
        acnt += int'(adp_rx_valid);
        quiet = (pcm_sdo == 1'b0) && (adp_sdo == 1'b0);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] po_a, ao_a, po_b, ao_b, m, ain_a, ain_b;
        int pc_a, ac_a, pc_b, ac_b;
        logic q_a, q_b, w;

        // R10: reset values
        repeat (3) @(posedge bclk);
        #2;
        chk("R10 sdo", {30'd0, pcm_sdo, adp_sdo}, 32'd0);
        chk("R10 valids", {30'd0, pcm_rx_valid, adp_rx_valid}, 32'd0);
        chk("R10 pcm_rx_word", {16'd0, pcm_rx_word}, 32'd0);
        chk("R10 adp_rx_code", {24'd0, adp_rx_code}, 32'd0);
        @(negedge bclk); rst_n = 1'b1;
        repeat (2) @(posedge bclk);

        // table of vectors: each runs window A then window B
        for (int i = 0; i < NV; i++) begin
            rate_sel    = VECS[i].rate;
            slot_sel    = VECS[i].slot;
            pcm_tx_word = VECS[i].ptx;
            adp_tx_code = VECS[i].atx;
            m = exp_mask(VECS[i].rate);
            w = VECS[i].rate[1] ? VECS[i].slot : 1'b0;
            ain_a = (w == 1'b0) ? VECS[i].ain : ~VECS[i].ain;
            ain_b = (w == 1'b1) ? VECS[i].ain : ~VECS[i].ain;

            run_win(1'b0, VECS[i].pin[15:8], ain_a, po_a, ao_a, pc_a, ac_a, q_a);
            pcm_tx_word = ~VECS[i].ptx;   // R11: must not reach window B
            run_win(1'b1, VECS[i].pin[7:0], ain_b, po_b, ao_b, pc_b, ac_b, q_b);

            chk("R1 high octet", {24'd0, po_a}, {24'd0, VECS[i].ptx[15:8]});
            chk("R11 low octet", {24'd0, po_b}, {24'd0, VECS[i].ptx[7:0]});
            chk("R2 pcm_rx_word", {16'd0, pcm_rx_word}, {16'd0, VECS[i].pin});
            chk("R3 no valid in A", pc_a, 0);
            chk("R3 one valid after B", pc_b, 1);
            chk("R8 quiet after windows", {30'd0, q_a, q_b}, 32'd3);
            chk({rate_req(VECS[i].rate), " adp tx"}, {24'd0, (w ? ao_b : ao_a)},
                {24'd0, VECS[i].atx & m});
            chk({rate_req(VECS[i].rate), " adp rx"}, {24'd0, adp_rx_code},
                {24'd0, VECS[i].ain & m});
            chk("R8 adp other window", {24'd0, (w ? ao_a : ao_b)}, 32'd0);
            chk("R7 adp valid count", (w ? ac_b : ac_a), 1);
            chk("R7 no adp valid other", (w ? ac_a : ac_b), 0);
        end

        // R8: no strobe, outputs stay low
        pcm_tx_word = 16'hFFFF;
        adp_tx_code = 8'hFF;
        rate_sel = 2'b10;
        repeat (5) @(posedge bclk);
        #2;
        chk("R8 idle sdo", {30'd0, pcm_sdo, adp_sdo}, 32'd0);

        // R9: strobe A rises again in mid window
        rate_sel = 2'b00;
        pcm_tx_word = 16'h00FF;
        @(negedge bclk); #1; strobe_a = 1'b1;
        repeat (3) @(posedge bclk);
        @(negedge bclk); #1; strobe_a = 1'b0; pcm_tx_word = 16'h8000;
        @(posedge bclk);
        @(negedge bclk); #1; strobe_a = 1'b1;
        @(posedge bclk); #2;
        chk("R9 restart bit0", {31'd0, pcm_sdo}, 32'd1);
        @(posedge bclk); #2;
        chk("R9 restart bit1", {31'd0, pcm_sdo}, 32'd0);
        repeat (6) @(posedge bclk);
        @(negedge bclk); #1; strobe_a = 1'b0;
        repeat (3) @(posedge bclk);
        #2;
        chk("R8 idle after restart", {30'd0, pcm_sdo, adp_sdo}, 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule